// File: doc/BRIEF.md
# Event-Driven Spiking Neuron Core

This block is a compact digital core of leaky integrate-and-fire neurons. A binary connection matrix joins a set of input lines (axons) to a set of neurons. Incoming spikes arrive as axon numbers on a valid/ready channel and are taken one at a time. Each accepted number selects one matrix row. Every neuron whose bit in that row is set adds its own signed weight to its membrane potential. The potential saturates at its limits and never wraps.

A single-cycle `tick` pulse closes the time step. Each neuron adds its signed leak to its potential and compares the result with its signed threshold. A neuron that lies strictly above its threshold fires and its potential becomes zero. The indices of the fired neurons then leave on a second valid/ready channel, lowest index first. Input events are refused until the last index has been taken. A tick that arrives while a row is being applied, or while spikes are still draining, is held and served once the core is idle again.

Connection rows, weights, leaks and thresholds are loaded through a write-only configuration port. A write takes effect only in a cycle where the core is idle.

Top module: `spike_core`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and all connection bits, weights, leaks, thresholds and potentials are zero. With that state, events followed by a tick produce no output.
- R2: An event is accepted in a cycle where `in_valid` and `in_ready` are both 1. In the next cycle `in_ready` is 0, and each neuron j whose bit j of row `in_axon` is 1 adds its weight to its potential. Neurons whose bit is 0 are not changed.
- R3: Potentials are `POT_W`-bit two's complement values. A sum above 2^(POT_W-1)-1 or below -2^(POT_W-1) is clamped to that limit.
- R4: On a tick, each neuron computes potential plus leak (saturated). It fires only when that value is strictly greater than its threshold, both compared as signed numbers. A firing neuron's potential becomes exactly zero; a non-firing neuron keeps the leaked value.
- R5: Fired neuron indices are sent one per `out_valid`/`out_ready` handshake in ascending order. While `out_ready` is 0, `out_valid` stays 1 and `out_neuron` does not change.
- R6: `in_ready` is 0 from the cycle that takes a tick until the cycle after the last fired index has been sent.
- R7: A tick that arrives in the cycle a row is being applied is not lost. It is served after the row, and that row's contribution counts toward the threshold test.
- R8: A configuration write is made when `cfg_we` is 1, and `cfg_sel` picks the target. The codes are: 0 writes connection row `cfg_addr` from the low `NUM_NEURONS` bits of `cfg_data`; 1 writes the weight of neuron `cfg_addr`; 2 writes its leak; 3 writes its threshold. Codes 1 to 3 use the low `POT_W` bits of `cfg_data`. A write while the core is not idle is ignored.
- R9: A tick where no neuron exceeds its threshold returns the core to idle without raising `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target code |
| cfg_addr | input | max(log2 NUM_AXONS, log2 NUM_NEURONS) | Row or neuron number |
| cfg_data | input | max(NUM_NEURONS, POT_W) | Row bits or signed parameter value |
| in_valid | input | 1 | Input event present |
| in_ready | output | 1 | Core can take an event |
| in_axon | input | log2 NUM_AXONS | Axon number of the event |
| tick | input | 1 | Time-step synchronisation pulse |
| out_valid | output | 1 | Fired neuron index present |
| out_ready | input | 1 | Consumer takes the index |
| out_neuron | output | log2 NUM_NEURONS | Fired neuron index |

## Verification
The hardest case to reach from the ports is a tick that lands in the one cycle when a row is being applied, because only that cycle exercises the deferral path. The stimulus raises `in_valid` and confirms the acceptance edge. It then drops `in_valid` and pulses `tick` for exactly the following edge. The expected outcome is chosen so that the neuron fires only if the row was applied first and the tick was kept. Saturation is brought out through the threshold test: the weights are chosen so that a wrapped sum would land on the other side of the threshold from the clamped one.

// File: rtl/snn_pkg.sv
package snn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_FIRE = 2'd2,
        ST_EMIT = 2'd3
    } core_state_e;

    typedef enum logic [1:0] {
        CFG_ROW    = 2'd0,
        CFG_WEIGHT = 2'd1,
        CFG_LEAK   = 2'd2,
        CFG_THRESH = 2'd3
    } cfg_sel_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/snn_crossbar.sv
module snn_crossbar #(
    parameter int NUM_AXONS   = 16,
    parameter int NUM_NEURONS = 8,
    parameter int AXON_W      = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AXON_W-1:0]      wr_addr,
    input  logic [NUM_NEURONS-1:0] wr_row,
    input  logic [AXON_W-1:0]      rd_addr,
    output logic [NUM_NEURONS-1:0] rd_row
);

    logic [NUM_NEURONS-1:0] rows [NUM_AXONS];

    for (genvar r = 0; r < NUM_AXONS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows[r] <= '0;
            end else if (wr_en && (wr_addr == AXON_W'(r))) begin
                rows[r] <= wr_row;
            end
        end
    end

    assign rd_row = rows[rd_addr];

endmodule

// File: rtl/snn_neuron.sv
module snn_neuron #(
    parameter int POT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POT_W-1:0] cfg_val,
    input  logic             wgt_we,
    input  logic             leak_we,
    input  logic             thr_we,
    input  logic             syn_hit,
    input  logic             fire_en,
    output logic             fire
);

    localparam logic signed [POT_W-1:0] POT_MAX = {1'b0, {(POT_W-1){1'b1}}};
    localparam logic signed [POT_W-1:0] POT_MIN = {1'b1, {(POT_W-1){1'b0}}};

    logic signed [POT_W-1:0] pot, wgt, leak, thr;
    logic signed [POT_W-1:0] leaked, charged;

    function automatic logic signed [POT_W-1:0] sat_add(
        input logic signed [POT_W-1:0] a,
        input logic signed [POT_W-1:0] b
    );
        logic signed [POT_W:0] s;
        s = {a[POT_W-1], a} + {b[POT_W-1], b};
        if (s[POT_W] != s[POT_W-1]) begin
            return s[POT_W] ? POT_MIN : POT_MAX;
        end
        return s[POT_W-1:0];
    endfunction

    always_comb begin
        leaked  = sat_add(pot, leak);
        charged = sat_add(pot, wgt);
        fire    = fire_en && (leaked > thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pot  <= '0;
            wgt  <= '0;
            leak <= '0;
            thr  <= '0;
        end else begin
            if (wgt_we)  wgt  <= cfg_val;
            if (leak_we) leak <= cfg_val;
            if (thr_we)  thr  <= cfg_val;
            if (fire_en) begin
                pot <= fire ? '0 : leaked;
            end else if (syn_hit) begin
                pot <= charged;
            end
        end
    end

    // R4: a fired neuron holds exactly zero afterwards
    assert_fire_resets_R4: assert property (@(posedge clk) disable iff (rst)
        fire |=> (pot == '0));

    // R3: a positive input at the ceiling keeps the potential at the ceiling
    assert_pos_clamp_R3: assert property (@(posedge clk) disable iff (rst)
        (syn_hit && !fire_en && (pot == POT_MAX) && (wgt > 0) && !wgt_we) |=> (pot == POT_MAX));

endmodule

// File: rtl/snn_spike_encoder.sv
module snn_spike_encoder #(
    parameter int NUM_NEURONS = 8,
    parameter int NEURON_W    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [NUM_NEURONS-1:0] load_mask,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [NEURON_W-1:0]    out_idx
);

    logic [NUM_NEURONS-1:0] mask;
    logic [NUM_NEURONS-1:0] clr_vec;

    always_comb begin
        out_idx = '0;
        for (int i = NUM_NEURONS - 1; i >= 0; i--) begin
            if (mask[i]) out_idx = NEURON_W'(i);
        end
        clr_vec = '0;
        clr_vec[out_idx] = 1'b1;
        out_valid = |mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (load) begin
            mask <= load_mask;
        end else if (out_valid && out_ready) begin
            mask <= mask & ~clr_vec;
        end
    end

    // R5: index held steady under backpressure
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_idx)));

    // R5: successive indices strictly ascend
    assert_ascending_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !load) |=> (!out_valid || (out_idx > $past(out_idx))));

endmodule

// File: rtl/spike_core.sv
module spike_core
    import snn_pkg::*;
#(
    parameter int NUM_AXONS   = 16,
    parameter int NUM_NEURONS = 8,
    parameter int POT_W       = 12,
    localparam int AXON_W     = $clog2(NUM_AXONS),
    localparam int NEURON_W   = $clog2(NUM_NEURONS),
    localparam int ADDR_W     = max_int(AXON_W, NEURON_W),
    localparam int CFG_W      = max_int(NUM_NEURONS, POT_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [AXON_W-1:0]   in_axon,
    input  logic                tick,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [NEURON_W-1:0] out_neuron
);

    core_state_e            state;
    logic                   tick_pend;
    logic [AXON_W-1:0]      axon_q;
    logic [NUM_NEURONS-1:0] row_bits;
    logic [NUM_NEURONS-1:0] fire_vec;
    logic                   cfg_ok;
    cfg_sel_e               sel;
    logic                   row_en, fire_en;

    assign sel      = cfg_sel_e'(cfg_sel);
    assign cfg_ok   = cfg_we && (state == ST_IDLE);
    assign row_en   = (state == ST_ROW);
    assign fire_en  = (state == ST_FIRE);
    assign in_ready = (state == ST_IDLE) && !tick && !tick_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tick_pend <= 1'b0;
            axon_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (tick || tick_pend) begin
                        state     <= ST_FIRE;
                        tick_pend <= 1'b0;
                    end else if (in_valid) begin
                        axon_q <= in_axon;
                        state  <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    state <= ST_IDLE;
                    if (tick) tick_pend <= 1'b1;
                end
                ST_FIRE: begin
                    state <= (|fire_vec) ? ST_EMIT : ST_IDLE;
                    if (tick) tick_pend <= 1'b1;
                end
                default: begin
                    if (!out_valid) state <= ST_IDLE;
                    if (tick) tick_pend <= 1'b1;
                end
            endcase
        end
    end

    snn_crossbar #(
        .NUM_AXONS   (NUM_AXONS),
        .NUM_NEURONS (NUM_NEURONS),
        .AXON_W      (AXON_W)
    ) xbar_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_ok && (sel == CFG_ROW)),
        .wr_addr (cfg_addr[AXON_W-1:0]),
        .wr_row  (cfg_data[NUM_NEURONS-1:0]),
        .rd_addr (axon_q),
        .rd_row  (row_bits)
    );

    for (genvar j = 0; j < NUM_NEURONS; j++) begin : g_neuron
        logic addr_hit;
        assign addr_hit = cfg_ok && (cfg_addr == ADDR_W'(j));
        snn_neuron #(.POT_W(POT_W)) neuron_i (
            .clk     (clk),
            .rst     (rst),
            .cfg_val (cfg_data[POT_W-1:0]),
            .wgt_we  (addr_hit && (sel == CFG_WEIGHT)),
            .leak_we (addr_hit && (sel == CFG_LEAK)),
            .thr_we  (addr_hit && (sel == CFG_THRESH)),
            .syn_hit (row_en && row_bits[j]),
            .fire_en (fire_en),
            .fire    (fire_vec[j])
        );
    end

    snn_spike_encoder #(
        .NUM_NEURONS (NUM_NEURONS),
        .NEURON_W    (NEURON_W)
    ) enc_i (
        .clk       (clk),
        .rst       (rst),
        .load      (fire_en),
        .load_mask (fire_vec),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_idx   (out_neuron)
    );

    // R6: no input accepted while spikes drain
    assert_no_input_while_emit_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R2: an accepted event blocks the channel for the row cycle
    assert_row_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R7: a tick seen during a row cycle leads to a fire phase two cycles on
    assert_tick_deferred_R7: assert property (@(posedge clk) disable iff (rst)
        (row_en && tick) |=> ##1 fire_en);

endmodule

// File: tb/spike_core_tb_top.sv
module spike_core_tb_top;

    localparam int K = 16;
    localparam int N = 8;
    localparam int P = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [3:0]  cfg_addr = '0;
    logic [11:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_axon = '0;
    logic        tick = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_neuron;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spike_core #(.NUM_AXONS(K), .NUM_NEURONS(N), .POT_W(P)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_axon    (in_axon),
        .tick       (tick),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_neuron (out_neuron)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; tick = 1'b0; cfg_we = 1'b0; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input int sel, input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 4'(addr); cfg_data = 12'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_event(input int ax, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_axon = 4'(ax);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, req, int'(in_ready), 0);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic expect_spikes(input logic [N-1:0] exp, input string req);
        int got [N];
        int cnt = 0;
        int n_exp = 0;
        int k = 0;
        for (int w = 0; w < 100 && !in_ready; w++) begin
            if (out_valid && out_ready) begin
                if (cnt < N) got[cnt] = int'(out_neuron);
                cnt++;
            end
            @(negedge clk);
        end
        for (int i = 0; i < N; i++) if (exp[i]) n_exp++;
        check(cnt == n_exp, {req, " spike count"}, cnt, n_exp);
        for (int i = 0; i < N; i++) begin
            if (exp[i]) begin
                if (k < cnt && k < N) check(got[k] == i, {req, " spike order"}, got[k], i);
                k++;
            end
        end
    endtask

    // R1, R9
    task automatic t_reset();
        do_reset();
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        send_event(0, "R2");
        send_event(7, "R2");
        pulse_tick();
        expect_spikes(8'h00, "R1 R9 zeroed config");
    endtask

    // R2, R4, R5, R8
    task automatic t_basic();
        do_reset();
        cfg_write(0, 3, 8'b0000_0101);
        cfg_write(0, 5, 8'b0000_0010);
        for (int j = 0; j < 3; j++) begin
            cfg_write(1, j, 5);
            cfg_write(3, j, 9);
        end
        send_event(3, "R2");
        send_event(3, "R2");
        send_event(5, "R2");
        pulse_tick();
        expect_spikes(8'b0000_0101, "R2 R8 row hits");
        pulse_tick();
        expect_spikes(8'h00, "R4 reset to zero");
        send_event(5, "R2");
        pulse_tick();
        expect_spikes(8'b0000_0010, "R4 kept potential");
    endtask

    // R4 strict compare
    task automatic t_equal();
        do_reset();
        cfg_write(0, 9, 8'b0000_1000);
        cfg_write(1, 3, 4);
        cfg_write(3, 3, 8);
        send_event(9, "R2");
        send_event(9, "R2");
        pulse_tick();
        expect_spikes(8'h00, "R4 equal no fire");
        send_event(9, "R2");
        pulse_tick();
        expect_spikes(8'b0000_1000, "R4 above fires");
    endtask

    // R4 leak and negative threshold
    task automatic t_leak();
        do_reset();
        cfg_write(2, 7, 3);
        cfg_write(3, 7, 5);
        cfg_write(3, 6, -1);
        pulse_tick();
        expect_spikes(8'b0100_0000, "R4 leak step one");
        pulse_tick();
        expect_spikes(8'b1100_0000, "R4 leak step two");
    endtask

    // R3 saturation both directions
    task automatic t_sat();
        do_reset();
        cfg_write(0, 2, 8'b0000_0011);
        cfg_write(1, 0, 1000);
        cfg_write(1, 1, -1000);
        cfg_write(3, 0, 2000);
        cfg_write(3, 1, 1000);
        for (int e = 0; e < 3; e++) send_event(2, "R2");
        pulse_tick();
        expect_spikes(8'b0000_0001, "R3 clamp");
    endtask

    // R5, R6, R8 busy
    task automatic t_backpressure();
        do_reset();
        for (int j = 0; j < N; j++) cfg_write(3, j, -1);
        @(negedge clk);
        out_ready = 1'b0;
        pulse_tick();
        @(negedge clk);
        in_valid = 1'b1; in_axon = 4'd0;
        for (int c = 0; c < 5; c++) begin
            check(out_valid == 1'b1, "R5 valid held", int'(out_valid), 1);
            check(out_neuron == 3'd0, "R5 index held", int'(out_neuron), 0);
            check(in_ready == 1'b0, "R6 input refused", int'(in_ready), 0);
            cfg_we = 1'b1; cfg_sel = 2'd3; cfg_addr = 4'd3; cfg_data = 12'd2000;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b1;
        expect_spikes(8'hFF, "R5 ascending drain");
        check(in_ready == 1'b1, "R6 ready after drain", int'(in_ready), 1);
        pulse_tick();
        expect_spikes(8'hFF, "R8 busy write ignored");
    endtask

    // R7 tick during the row cycle
    task automatic t_defer();
        do_reset();
        cfg_write(0, 1, 8'b0001_0000);
        cfg_write(1, 4, 5);
        cfg_write(3, 4, 4);
        @(negedge clk);
        in_valid = 1'b1; in_axon = 4'd1;
        check(in_ready == 1'b1, "R7 idle before event", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        tick = 1'b1;
        check(in_ready == 1'b0, "R7 row cycle", int'(in_ready), 0);
        @(negedge clk);
        tick = 1'b0;
        expect_spikes(8'b0001_0000, "R7 deferred tick");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_equal();
        t_leak();
        t_sat();
        t_backpressure();
        t_defer();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule